// File: doc/BRIEF.md
# SPI Transmit Completion Controller

This block is an SPI master transmitter with a small transmit queue. Around it sits the logic that tells software when a transfer has ended. Software sets a transfer length, a frame width and a clock divider while the block is disabled. It then enables the block, pushes words, issues start and suspend commands, clears event flags by writing ones to a clear strobe, and sets one interrupt enable for completion events. The block drives a serial clock and a serial data line in clock mode 0, with the most significant bit first.

Two completion styles exist. With a transfer length of zero the link is an endless stream. The transmit-complete level then follows the hardware: it is high whenever the queue is empty and no frame is on the wire, and this includes the moment right after enable. Software cannot clear it; only a new write takes it down. With a nonzero length, a separate remaining-frames counter is loaded from the programmed value and counts down once per sent frame. When the last frame has left, an end-of-transfer event and the transmit-complete level both rise.

Top module: `spi_tx_eot_ctrl`

## Requirements
- R1: With a programmed length of zero, `txc` is 1 whenever `en` is 1, the queue is empty and no frame is being shifted, including the first cycles after enable before any write.
- R2: Writing the clear strobe never lowers `txc`; in zero-length mode `txc` falls only in the cycle after an accepted write.
- R3: `irq` is 1 exactly when `eot_ie` is 1 and at least one of `txc`, `eot`, `susp` is 1.
- R4: When `clr_we` is 1, each `clr_bits` bit set to 1 clears one sticky flag (bit 0 `eot`, bit 1 `susp`, bit 2 `ovr`), and bits at 0 leave their flag unchanged; a flag being set in the same cycle stays set.
- R5: `tsize` is captured in every disabled cycle and held while enabled; `cur_size` shows the captured value and, in nonzero mode, decreases by one when each frame completes, while later changes of `tsize` have no effect.
- R6: In nonzero mode `txtf` rises once the accepted writes equal the captured length, further writes are ignored without raising `ovr`, and when `cur_size` reaches 0 `eot` sets, `txc` rises and shifting stops.
- R7: No frame starts before `start_cmd`; `susp_cmd` while running stops transmission at the next frame boundary and sets `susp`, and a later `start_cmd` resumes it.
- R8: A frame is `frame_len_m1`+1 bits long and is sent MSB first. `sck` idles low and each half period lasts 2^`baud_sel` clock cycles. `mosi` changes only on falling `sck` or at frame load, and `mosi` is 0 when idle.
- R9: `txp` is 1 while enabled and the 4-entry queue has a free entry; a write to a full queue is dropped and sets the sticky `ovr` flag.
- R10: While `en` is 0, any frame in progress is aborted, the queue is flushed, all status flags read 0, `sck` and `mosi` are 0, and `cur_size` reloads from `tsize`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low aborts and flushes |
| start_cmd | input | 1 | Start/resume pulse |
| susp_cmd | input | 1 | Suspend request pulse |
| wr_valid | input | 1 | Push a word into the queue |
| wr_data | input | 16 | Word to push |
| clr_we | input | 1 | Flag clear strobe |
| clr_bits | input | 3 | Clear mask: bit0 eot, bit1 susp, bit2 ovr |
| eot_ie | input | 1 | Completion interrupt enable |
| tsize | input | 16 | Transfer length in frames, 0 = stream |
| frame_len_m1 | input | 4 | Frame width minus one |
| baud_sel | input | 3 | Half period is 2^baud_sel cycles |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| cur_size | output | 16 | Remaining frames |
| txc | output | 1 | Transmit complete level |
| eot | output | 1 | End of transfer event |
| susp | output | 1 | Suspended event |
| txtf | output | 1 | All words of the transfer written |
| txp | output | 1 | Queue has room |
| ovr | output | 1 | Write to full queue occurred |
| irq | output | 1 | Completion interrupt |

## Verification
The bench goes after the completion level right after enable with nothing written. A design that gates it on a first transfer would stay silent there, while one that treats it as a clearable event would drop it on a clear write. It also drives a suspend issued while idle and a write into a full queue next to a clear with an all-zero mask. A design that got these wrong would lose the suspend, wrap the queue or wipe flags it should keep. In the counted mode it writes one word past the length and changes the length input mid-transfer. A design that gets this wrong sends a fourth frame, flags an overflow, or reloads the remaining count.

// File: rtl/spi_eot_pkg.sv
package spi_eot_pkg;

    localparam int CLR_EOT  = 0;
    localparam int CLR_SUSP = 1;
    localparam int CLR_OVR  = 2;
    localparam int CLR_W    = 3;

    typedef struct packed {
        logic ovr;
        logic susp;
        logic eot;
    } evt_flags_t;

    typedef struct packed {
        logic [3:0] len_m1;
        logic [2:0] baud;
    } frame_cfg_t;

    // Terminal count of the half-period divider for a baud select value.
    function automatic logic [7:0] half_m1(input logic [2:0] b);
        return (8'd1 << b) - 8'd1;
    endfunction

endpackage

// File: rtl/spi_txq.sv
module spi_txq #(
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= nxt(wp);
            if (pop)  rp <= nxt(rp);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wp] <= din;
    end

    assign head = mem[rp];

    p_push_room_r9: assert property (@(posedge clk) disable iff (rst)
        push |-> (count < CW'(DEPTH)));
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
    import spi_eot_pkg::*;
#(
    parameter int DW = 16,
    localparam int LW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          abort,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic [LW-1:0] len_m1,
    input  logic [2:0]    baud,
    output logic          busy,
    output logic          done,
    output logic          sck,
    output logic          mosi
);
    logic [DW-1:0] sh;
    logic [LW-1:0] bits;
    logic [7:0]    div;
    logic          tick;

    assign tick = (div == half_m1(baud));

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy <= 1'b0;
            sck  <= 1'b0;
            sh   <= '0;
            bits <= '0;
            div  <= '0;
        end else if (busy) begin
            if (tick) begin
                div <= '0;
                if (!sck) begin
                    sck <= 1'b1;
                end else begin
                    sck <= 1'b0;
                    sh  <= sh << 1;
                    if (bits == '0) busy <= 1'b0;
                    else            bits <= bits - LW'(1);
                end
            end else begin
                div <= div + 8'd1;
            end
        end else if (load) begin
            busy <= 1'b1;
            sh   <= din << (LW'(DW - 1) - len_m1);
            bits <= len_m1;
            div  <= '0;
            sck  <= 1'b0;
        end
    end

    assign done = busy && tick && sck && (bits == '0);
    assign mosi = busy & sh[DW-1];

    p_sck_idle_low_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck);
    p_mosi_hold_rise_r8: assert property (@(posedge clk) disable iff (rst || abort)
        $rose(sck) |-> $stable(mosi));
endmodule

// File: rtl/spi_eot_status.sv
module spi_eot_status
    import spi_eot_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SW-1:0]    tsize,
    input  logic             frame_done,
    input  logic             wr_accept,
    input  logic             suspend_take,
    input  logic             ovr_set,
    input  logic             clr_we,
    input  logic [CLR_W-1:0] clr_bits,
    input  logic             fifo_empty,
    input  logic             shifter_busy,
    output logic [SW-1:0]    cur_size,
    output logic             capped,
    output logic             eot_set,
    output evt_flags_t       flags,
    output logic             txc,
    output logic             txtf
);
    logic [SW-1:0] ts_q, wcnt_q;
    logic          sized;
    evt_flags_t    clr;

    assign sized   = (ts_q != '0);
    assign capped  = sized && (wcnt_q >= ts_q);
    assign eot_set = sized && frame_done && (cur_size == SW'(1));
    assign clr     = clr_we ? evt_flags_t'(clr_bits) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_q     <= '0;
            cur_size <= '0;
            wcnt_q   <= '0;
            flags    <= '0;
        end else if (!en) begin
            ts_q     <= tsize;
            cur_size <= tsize;
            wcnt_q   <= '0;
            flags    <= '0;
        end else begin
            if (sized && frame_done) cur_size <= cur_size - SW'(1);
            if (wr_accept)           wcnt_q   <= wcnt_q + SW'(1);
            flags.eot  <= eot_set      | (flags.eot  & ~clr.eot);
            flags.susp <= suspend_take | (flags.susp & ~clr.susp);
            flags.ovr  <= ovr_set      | (flags.ovr  & ~clr.ovr);
        end
    end

    assign txc  = en && (sized ? (cur_size == '0) : (fifo_empty && !shifter_busy));
    assign txtf = en && capped;

    p_eot_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.eot) |-> (cur_size == '0));
    p_size_held_r5: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en)) |-> $stable(ts_q));
    p_txc_fall_r2: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !sized && $fell(txc)) |-> $past(wr_accept));
endmodule

// File: rtl/spi_tx_eot_ctrl.sv
module spi_tx_eot_ctrl
    import spi_eot_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 4,
    parameter int SW    = 16,
    parameter int LW    = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             start_cmd,
    input  logic             susp_cmd,
    input  logic             wr_valid,
    input  logic [DW-1:0]    wr_data,
    input  logic             clr_we,
    input  logic [CLR_W-1:0] clr_bits,
    input  logic             eot_ie,
    input  logic [SW-1:0]    tsize,
    input  logic [LW-1:0]    frame_len_m1,
    input  logic [2:0]       baud_sel,
    output logic             sck,
    output logic             mosi,
    output logic [SW-1:0]    cur_size,
    output logic             txc,
    output logic             eot,
    output logic             susp,
    output logic             txtf,
    output logic             txp,
    output logic             ovr,
    output logic             irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [LW-1:0] len_q;
    logic [2:0]    baud_q;
    logic          running_q, spend_q;
    logic [DW-1:0] head;
    logic [CW-1:0] count;
    logic          full, empty, busy, done, capped, eot_set;
    logic          load, suspend_take, wr_accept, ovr_set;
    evt_flags_t    flags;

    assign full         = (count == CW'(DEPTH));
    assign empty        = (count == '0);
    assign load         = en && running_q && !spend_q && !busy && !empty;
    assign suspend_take = en && spend_q && !busy;
    assign wr_accept    = en && wr_valid && !capped && !full;
    assign ovr_set      = en && wr_valid && !capped && full;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= '0;
            baud_q <= '0;
        end else if (!en) begin
            len_q  <= frame_len_m1;
            baud_q <= baud_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            running_q <= 1'b0;
            spend_q   <= 1'b0;
        end else begin
            if (eot_set || suspend_take) running_q <= 1'b0;
            else if (start_cmd)          running_q <= 1'b1;
            if (suspend_take)                spend_q <= 1'b0;
            else if (susp_cmd && running_q)  spend_q <= 1'b1;
        end
    end

    spi_txq #(.DEPTH(DEPTH), .DW(DW)) u_q (
        .clk(clk), .rst(rst), .flush(!en), .push(wr_accept), .din(wr_data),
        .pop(load), .head(head), .count(count)
    );

    spi_frame_shifter #(.DW(DW)) u_sh (
        .clk(clk), .rst(rst), .abort(!en), .load(load), .din(head),
        .len_m1(len_q), .baud(baud_q), .busy(busy), .done(done),
        .sck(sck), .mosi(mosi)
    );

    spi_eot_status #(.SW(SW)) u_st (
        .clk(clk), .rst(rst), .en(en), .tsize(tsize), .frame_done(done),
        .wr_accept(wr_accept), .suspend_take(suspend_take), .ovr_set(ovr_set),
        .clr_we(clr_we), .clr_bits(clr_bits), .fifo_empty(empty),
        .shifter_busy(busy), .cur_size(cur_size), .capped(capped),
        .eot_set(eot_set), .flags(flags), .txc(txc), .txtf(txtf)
    );

    assign eot  = flags.eot;
    assign susp = flags.susp;
    assign ovr  = flags.ovr;
    assign txp  = en && !full;
    assign irq  = eot_ie && (txc || eot || susp);

    p_susp_boundary_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(susp) |-> !busy);
endmodule

// File: tb/tb_spi_tx_eot_ctrl.sv
module tb_spi_tx_eot_ctrl;
    localparam int DEPTH = 4;

    logic        clk = 0, rst = 1, en = 0, start_cmd = 0, susp_cmd = 0;
    logic        wr_valid = 0, clr_we = 0, eot_ie = 0;
    logic [15:0] wr_data = 0, tsize = 0;
    logic [2:0]  clr_bits = 0, baud_sel = 0;
    logic [3:0]  frame_len_m1 = 15;
    logic        sck, mosi, txc, eot, susp, txtf, txp, ovr, irq;
    logic [15:0] cur_size;

    int checks = 0, errors = 0, cycles = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    spi_tx_eot_ctrl dut (
        .clk(clk), .rst(rst), .en(en), .start_cmd(start_cmd), .susp_cmd(susp_cmd),
        .wr_valid(wr_valid), .wr_data(wr_data), .clr_we(clr_we), .clr_bits(clr_bits),
        .eot_ie(eot_ie), .tsize(tsize), .frame_len_m1(frame_len_m1), .baud_sel(baud_sel),
        .sck(sck), .mosi(mosi), .cur_size(cur_size), .txc(txc), .eot(eot), .susp(susp),
        .txtf(txtf), .txp(txp), .ovr(ovr), .irq(irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_q[$];
    bit m_busy, m_sck, m_run, m_spend, m_eot, m_susp, m_ovr;
    int m_word, m_bits, m_div, m_half, m_flen, m_ts, m_cur, m_wcnt;
    bit full_n, capped_n, acc, ovs, ld, take, dn, eots, pre_run;

    always @(posedge clk) begin
        if (rst) begin
            m_q.delete();
            {m_busy, m_sck, m_run, m_spend, m_eot, m_susp, m_ovr} = '0;
            m_word = 0; m_bits = 0; m_div = 0; m_half = 1; m_flen = 1;
            m_ts = 0; m_cur = 0; m_wcnt = 0;
        end else if (!en) begin
            m_q.delete();
            {m_busy, m_sck, m_run, m_spend, m_eot, m_susp, m_ovr} = '0;
            m_ts = tsize; m_cur = tsize; m_wcnt = 0;
            m_flen = frame_len_m1 + 1; m_half = 1 << baud_sel;
        end else begin
            full_n   = (m_q.size() == DEPTH);
            capped_n = (m_ts != 0) && (m_wcnt >= m_ts);
            acc  = wr_valid && !capped_n && !full_n;
            ovs  = wr_valid && !capped_n && full_n;
            ld   = m_run && !m_spend && !m_busy && (m_q.size() > 0);
            take = m_spend && !m_busy;
            dn   = m_busy && (m_div == m_half - 1) && m_sck && (m_bits == 0);
            eots = (m_ts != 0) && dn && (m_cur == 1);
            if (m_busy) begin
                if (m_div == m_half - 1) begin
                    m_div = 0;
                    if (!m_sck) m_sck = 1;
                    else begin
                        m_sck = 0;
                        if (m_bits == 0) m_busy = 0; else m_bits--;
                    end
                end else m_div++;
            end else if (ld) begin
                m_word = m_q.pop_front();
                m_busy = 1; m_bits = m_flen - 1; m_div = 0; m_sck = 0;
            end
            if (acc) begin m_q.push_back(wr_data); m_wcnt++; end
            if ((m_ts != 0) && dn) m_cur--;
            pre_run = m_run;
            if (eots || take) m_run = 0; else if (start_cmd) m_run = 1;
            if (take) m_spend = 0; else if (susp_cmd && pre_run) m_spend = 1;
            m_eot  = eots || (m_eot  && !(clr_we && clr_bits[0]));
            m_susp = take || (m_susp && !(clr_we && clr_bits[1]));
            m_ovr  = ovs  || (m_ovr  && !(clr_we && clr_bits[2]));
        end
    end

    // Compare every cycle, half a period after the edge.
    bit e_txc;
    always @(negedge clk) begin
        if (!rst && !finished) begin
            e_txc = en && ((m_ts == 0) ? (m_q.size() == 0 && !m_busy) : (m_cur == 0));
            chk("R8", "sck",  sck,  m_sck);
            chk("R8", "mosi", mosi, m_busy ? ((m_word >> m_bits) & 1) : 0);
            chk("R1", "txc",  txc,  e_txc);
            chk("R6", "eot",  eot,  m_eot);
            chk("R7", "susp", susp, m_susp);
            chk("R6", "txtf", txtf, en && (m_ts != 0) && (m_wcnt >= m_ts));
            chk("R9", "txp",  txp,  en && (m_q.size() < DEPTH));
            chk("R9", "ovr",  ovr,  m_ovr);
            chk("R3", "irq",  irq,  eot_ie && (e_txc || m_eot || m_susp));
            chk("R5", "cur_size", cur_size, m_cur);
        end
    end

    // Independent serial receiver.
    int rx_len = 16, rx_n = 0, rx_acc = 0;
    int rx_q[$];
    always @(posedge sck) begin
        rx_acc = (rx_acc << 1) | mosi;
        rx_n++;
        if (rx_n == rx_len) begin
            rx_q.push_back(rx_acc & ((1 << rx_len) - 1));
            rx_n = 0; rx_acc = 0;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic push_word(input logic [15:0] d);
        wr_valid = 1; wr_data = d; cyc(1); wr_valid = 0;
    endtask

    task automatic pulse_start();  start_cmd = 1; cyc(1); start_cmd = 0; endtask
    task automatic pulse_susp();   susp_cmd = 1;  cyc(1); susp_cmd = 0;  endtask
    task automatic clear(input logic [2:0] m); clr_we = 1; clr_bits = m; cyc(1); clr_we = 0; clr_bits = 0; endtask

    task automatic expect_rx(input string req, input int words[$]);
        chk(req, "frames received", rx_q.size(), words.size());
        foreach (words[i]) if (i < rx_q.size()) chk(req, "frame data", rx_q[i], words[i]);
        rx_q.delete();
    endtask

    initial begin
        int n;
        cyc(3);
        @(negedge clk);
        chk("R10", "reset sck", sck, 0);
        chk("R10", "reset txc", txc, 0);
        chk("R10", "reset irq", irq, 0);
        chk("R10", "reset cur_size", cur_size, 0);
        rst = 0; cyc(2);

        // Stream mode, 16-bit frames, fastest clock
        en = 1; cyc(2);
        @(negedge clk);
        chk("R1", "txc right after enable", txc, 1);
        chk("R3", "irq masked", irq, 0);
        eot_ie = 1; cyc(1);
        @(negedge clk);
        chk("R3", "irq from txc", irq, 1);
        clear(3'b111);
        @(negedge clk);
        chk("R2", "txc after clear write", txc, 1);

        push_word(16'hA5C3); push_word(16'h0F01); push_word(16'h8000);
        @(negedge clk);
        chk("R2", "txc after writes", txc, 0);
        cyc(10);
        @(negedge clk);
        chk("R7", "no shifting before start", rx_n + rx_q.size(), 0);
        pulse_start();
        n = 0;
        do begin @(negedge clk); n++; end while (!txc && n < 500);
        expect_rx("R8", '{16'hA5C3, 16'h0F01, 16'h8000});

        // Suspend while idle, then overflow
        pulse_susp(); cyc(2);
        @(negedge clk);
        chk("R7", "susp set", susp, 1);
        clear(3'b010);
        @(negedge clk);
        chk("R4", "susp cleared", susp, 0);
        push_word(16'h1111); push_word(16'h2222); push_word(16'h3333); push_word(16'h4444);
        @(negedge clk);
        chk("R9", "txp full", txp, 0);
        push_word(16'h5555);
        @(negedge clk);
        chk("R9", "ovr set", ovr, 1);
        clear(3'b000);
        @(negedge clk);
        chk("R4", "zero mask keeps ovr", ovr, 1);
        clear(3'b100);
        @(negedge clk);
        chk("R4", "ovr cleared", ovr, 0);
        cyc(20);
        chk("R7", "held while suspended", rx_q.size(), 0);
        pulse_start();
        n = 0;
        do begin @(negedge clk); n++; end while (!txc && n < 800);
        expect_rx("R9", '{16'h1111, 16'h2222, 16'h3333, 16'h4444});

        // Disable mid-frame
        push_word(16'hFFFF); cyc(8);
        en = 0; cyc(1);
        @(negedge clk);
        chk("R10", "sck after disable", sck, 0);
        chk("R10", "txp after disable", txp, 0);
        chk("R10", "txc after disable", txc, 0);
        rx_n = 0; rx_acc = 0; rx_q.delete();

        // Counted mode, 8-bit frames, divide by 4
        tsize = 3; frame_len_m1 = 7; baud_sel = 1; rx_len = 8; cyc(2);
        @(negedge clk);
        chk("R10", "cur_size reload", cur_size, 3);
        en = 1; cyc(1);
        @(negedge clk);
        chk("R6", "txc low before data", txc, 0);
        push_word(16'h00C5); push_word(16'h003A); push_word(16'h0081);
        @(negedge clk);
        chk("R6", "txtf", txtf, 1);
        push_word(16'h00EE);
        @(negedge clk);
        chk("R6", "extra write no ovr", ovr, 0);
        chk("R6", "extra write dropped", txp, 1);
        tsize = 9;
        pulse_start();
        n = 0;
        do begin @(negedge clk); n++; end while (!eot && n < 1000);
        chk("R6", "eot", eot, 1);
        chk("R6", "txc at end", txc, 1);
        chk("R5", "cur_size zero", cur_size, 0);
        expect_rx("R6", '{8'hC5, 8'h3A, 8'h81});
        clear(3'b001);
        @(negedge clk);
        chk("R4", "eot cleared", eot, 0);
        chk("R2", "txc survives clear", txc, 1);
        cyc(40);
        chk("R6", "no fourth frame", rx_q.size(), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule